// File: doc/BRIEF.md
# Fan Tach Fault Monitor

This block judges a measured fan speed against two limits once per monitoring cycle. A pulse on `sample_valid` presents a 16-bit tach period count. A larger count means a slower fan. The block compares the count with a slow-speed limit and an over-speed limit. It keeps two host-visible sticky flags, and a host read strobe clears both of them.

Consecutive slow results are counted. A run of five declares a fan failure, which latches and drives an active-low fault pin. While the fan is being spun up, the slow check is suspended. When spin-up ends, the slow flag is forced on so that the host reviews the fan. After the host clears the over-speed flag, that flag stays silent until the fan has first come back within its limit. An interrupt request follows the two flags, gated by an enable.

Top module: `fan_tach_monitor`

## Requirements
- R1: On a sample taken with `spinup_active` low, the slow flag is set one cycle later when `tach_count >= slow_limit`.
- R2: On a sample with `tach_count <= fast_limit`, the over-speed flag is set one cycle later, provided the over-speed detector is armed. The detector is armed after reset.
- R3: A sample taken with `spinup_active` high never sets the slow flag and resets the consecutive-slow run to zero.
- R4: In the clock cycle after `spinup_active` goes from 1 to 0, the slow flag is set whatever the tach count is. It then stays set until a read.
- R5: `status_rd` clears both flags on the next edge. If a set condition occurs in the same cycle as the read, the set wins and the flag stays 1.
- R6: Each time the over-speed flag is set, the detector disarms. It re-arms only on a sample with `tach_count > fast_limit`, so a persisting over-speed does not set the flag again after a read.
- R7: Five consecutive slow samples, taken outside spin-up, drive `fan_fault_n` low one cycle after the fifth sample. Any non-slow sample resets the run, and so does a spin-up sample.
- R8: Fan failure stays latched until reset or a `fail_clr` pulse. A new failure in the same cycle as the clear wins. The over-speed condition never affects `fan_fault_n`.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one of the two flags is 1.
- R10: Synchronous reset clears both flags, the run and the failure. This gives `fan_fault_n`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe marking a monitoring-cycle result |
| tach_count | input | 16 | Tach period count; larger means slower |
| slow_limit | input | 16 | Count at or above which the fan is slow |
| fast_limit | input | 16 | Count at or below which the fan is over speed |
| spinup_active | input | 1 | High while the fan is in its spin-up phase |
| status_rd | input | 1 | Host read strobe; clears both flags |
| fail_clr | input | 1 | Clears the latched fan failure and the run counter |
| irq_en | input | 1 | Enables the interrupt request |
| slow_flag | output | 1 | Sticky fan-slow flag |
| fast_flag | output | 1 | Sticky over-speed flag |
| fan_fault_n | output | 1 | Active-low fan failure |
| irq | output | 1 | Interrupt request |

## Verification
A host read can land in the same cycle as an event that sets a flag. That event can be a slow sample, an over-speed sample on an armed detector, or the end of spin-up. The bench provokes this both in a long mixed sweep, where reads fall on every third cycle, and in directed steps. It judges the result by requiring the flag to read 1 in the following cycle. A second collision, a failure clear arriving together with the fifth slow sample, is driven directly. It must leave `fan_fault_n` low.

// File: rtl/fan_mon_pkg.sv
package fan_mon_pkg;

    localparam int TACH_W = 16;

    typedef struct packed {
        logic slow_hit;
        logic fast_hit;
    } tach_cmp_t;

    function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] lim);
        return (v >= lim) ? lim : v + 8'd1;
    endfunction

endpackage

// File: rtl/tach_compare.sv
module tach_compare
    import fan_mon_pkg::*;
#(
    parameter int CNT_W = TACH_W
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] slow_lim_i,
    input  logic [CNT_W-1:0] fast_lim_i,
    output tach_cmp_t        cmp_o
);

    always_comb begin
        cmp_o.slow_hit = (count_i >= slow_lim_i);
        cmp_o.fast_hit = (count_i <= fast_lim_i);
    end

endmodule

// File: rtl/slow_tracker.sv
module slow_tracker
    import fan_mon_pkg::*;
#(
    parameter int FAIL_RUNS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_i,
    input  logic spin_i,
    input  logic hit_i,
    input  logic rd_i,
    input  logic clr_i,
    output logic slow_flag_o,
    output logic failed_o
);

    localparam logic [7:0] RUN_LIM = 8'(FAIL_RUNS);

    logic [7:0] run_q, run_d;
    logic       spin_q;
    logic       slow_q, failed_q;
    logic       slow_eval, spin_end, reach;

    always_comb begin
        slow_eval = sample_i && !spin_i && hit_i;
        spin_end  = spin_q && !spin_i;
        run_d     = run_q;
        if (sample_i) begin
            run_d = slow_eval ? sat_inc(run_q, RUN_LIM) : 8'd0;
        end else if (clr_i) begin
            run_d = 8'd0;
        end
        reach = slow_eval && (run_d == RUN_LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 8'd0;
            spin_q   <= 1'b0;
            slow_q   <= 1'b0;
            failed_q <= 1'b0;
        end else begin
            run_q    <= run_d;
            spin_q   <= spin_i;
            slow_q   <= slow_eval || spin_end || (slow_q && !rd_i);
            if (reach)
                failed_q <= 1'b1;
            else if (clr_i)
                failed_q <= 1'b0;
        end
    end

    assign slow_flag_o = slow_q;
    assign failed_o    = failed_q;

    // R1: a slow sample outside spin-up raises the flag
    a_r1_slow_sets: assert property (@(posedge clk) disable iff (rst)
        (sample_i && !spin_i && hit_i) |=> slow_q);

    // R3: a spin-up sample empties the run
    a_r3_spin_resets_run: assert property (@(posedge clk) disable iff (rst)
        (sample_i && spin_i) |=> (run_q == 8'd0));

    // R4: end of spin-up forces the flag
    a_r4_spin_end_flag: assert property (@(posedge clk) disable iff (rst)
        (spin_q && !spin_i) |=> slow_q);

    // R7: failure only begins on a slow sample outside spin-up
    a_r7_fail_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(failed_q) |-> $past(sample_i && !spin_i && hit_i));

    // R7: a non-slow sample empties the run
    a_r7_run_reset: assert property (@(posedge clk) disable iff (rst)
        (sample_i && !spin_i && !hit_i) |=> (run_q == 8'd0));

endmodule

// File: rtl/overspeed_tracker.sv
module overspeed_tracker (
    input  logic clk,
    input  logic rst,
    input  logic sample_i,
    input  logic hit_i,
    input  logic rd_i,
    output logic fast_flag_o
);

    logic armed_q, fast_q, set_now;

    always_comb set_now = sample_i && hit_i && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            fast_q  <= 1'b0;
        end else begin
            fast_q <= set_now || (fast_q && !rd_i);
            if (set_now)
                armed_q <= 1'b0;
            else if (sample_i && !hit_i)
                armed_q <= 1'b1;
        end
    end

    assign fast_flag_o = fast_q;

    // R6: the flag only rises from an armed detector
    a_r6_rise_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_q) |-> $past(armed_q));

    // R5: read without a set clears the flag
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !set_now) |=> !fast_q);

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
    import fan_mon_pkg::*;
#(
    parameter int CNT_W     = TACH_W,
    parameter int FAIL_RUNS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid,
    input  logic [CNT_W-1:0] tach_count,
    input  logic [CNT_W-1:0] slow_limit,
    input  logic [CNT_W-1:0] fast_limit,
    input  logic             spinup_active,
    input  logic             status_rd,
    input  logic             fail_clr,
    input  logic             irq_en,
    output logic             slow_flag,
    output logic             fast_flag,
    output logic             fan_fault_n,
    output logic             irq
);

    tach_cmp_t cmp;
    logic      failed;

    tach_compare #(.CNT_W(CNT_W)) u_cmp (
        .count_i    (tach_count),
        .slow_lim_i (slow_limit),
        .fast_lim_i (fast_limit),
        .cmp_o      (cmp)
    );

    slow_tracker #(.FAIL_RUNS(FAIL_RUNS)) u_slow (
        .clk         (clk),
        .rst         (rst),
        .sample_i    (sample_valid),
        .spin_i      (spinup_active),
        .hit_i       (cmp.slow_hit),
        .rd_i        (status_rd),
        .clr_i       (fail_clr),
        .slow_flag_o (slow_flag),
        .failed_o    (failed)
    );

    overspeed_tracker u_fast (
        .clk         (clk),
        .rst         (rst),
        .sample_i    (sample_valid),
        .hit_i       (cmp.fast_hit),
        .rd_i        (status_rd),
        .fast_flag_o (fast_flag)
    );

    assign fan_fault_n = ~failed;
    assign irq         = irq_en && (slow_flag || fast_flag);

    // R8: failure holds without a clear
    a_r8_fault_latched: assert property (@(posedge clk) disable iff (rst)
        (!fan_fault_n && !fail_clr) |=> !fan_fault_n);

    // R9: interrupt request tracks enable and flags
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && (slow_flag || fast_flag)));

endmodule

// File: tb/fan_tach_monitor_tb.sv
module fan_tach_monitor_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid, spinup_active, status_rd, fail_clr, irq_en;
    logic [15:0] tach_count, slow_limit, fast_limit;
    logic        slow_flag, fast_flag, fan_fault_n, irq;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R10";

    // reference state
    bit m_slow, m_fast, m_armed, m_fail, m_spin_q;
    int m_run;

    always #2 clk = ~clk;

    fan_tach_monitor u_dut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .tach_count(tach_count),
        .slow_limit(slow_limit), .fast_limit(fast_limit), .spinup_active(spinup_active),
        .status_rd(status_rd), .fail_clr(fail_clr), .irq_en(irq_en),
        .slow_flag(slow_flag), .fast_flag(fast_flag), .fan_fault_n(fan_fault_n), .irq(irq)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("slow_flag", slow_flag, m_slow);
        chk("fast_flag", fast_flag, m_fast);
        chk("fan_fault_n", fan_fault_n, !m_fail);
        chk("irq", irq, irq_en && (m_slow || m_fast));
    endtask

    task automatic step(input bit smp, input int cnt, input bit spn, input bit rd, input bit clr);
        bit sh, fh, slow_set, fast_set, spin_end, reach;
        sample_valid  = smp;
        tach_count    = 16'(cnt);
        spinup_active = spn;
        status_rd     = rd;
        fail_clr      = clr;
        @(posedge clk);
        sh       = (cnt >= int'(slow_limit));
        fh       = (cnt <= int'(fast_limit));
        spin_end = m_spin_q && !spn;
        slow_set = smp && !spn && sh;
        reach    = 0;
        if (smp) begin
            if (slow_set) m_run = (m_run >= 5) ? 5 : m_run + 1; else m_run = 0;
            reach = slow_set && (m_run == 5);
        end else if (clr) m_run = 0;
        if (reach) m_fail = 1; else if (clr) m_fail = 0;
        m_slow   = slow_set || spin_end || (m_slow && !rd);
        fast_set = smp && fh && m_armed;
        m_fast   = fast_set || (m_fast && !rd);
        if (fast_set) m_armed = 0; else if (smp && !fh) m_armed = 1;
        m_spin_q = spn;
        @(negedge clk);
        check_all();
        sample_valid = 0; status_rd = 0; fail_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL R10 watchdog actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst = 1; sample_valid = 0; spinup_active = 0; status_rd = 0; fail_clr = 0;
        irq_en = 1; tach_count = 0; slow_limit = 16'd100; fast_limit = 16'd20;
        m_slow = 0; m_fast = 0; m_armed = 1; m_fail = 0; m_spin_q = 0; m_run = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cur_req = "R10";
        check_all();

        // R1: boundary around the slow limit
        cur_req = "R1";
        step(1, 99, 0, 0, 0);
        step(1, 100, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(1, 101, 0, 1, 0);   // R5 collision: read with a set
        step(0, 0, 0, 1, 0);

        // R2 / R6: over-speed boundary and re-arm
        cur_req = "R2";
        step(1, 21, 0, 0, 0);
        step(1, 20, 0, 0, 0);
        cur_req = "R6";
        step(0, 0, 0, 1, 0);
        step(1, 10, 0, 0, 0);    // persists, disarmed: no set
        step(1, 0, 0, 0, 0);
        step(1, 50, 0, 0, 0);    // back within limit: re-arm
        step(1, 20, 0, 0, 0);
        cur_req = "R5";
        step(1, 60, 0, 1, 0);
        step(1, 15, 0, 1, 0);    // armed set collides with read

        // R3 / R4: spin-up suppression and forced flag
        cur_req = "R3";
        step(1, 200, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        step(1, 200, 1, 0, 0);
        step(1, 300, 1, 0, 0);
        cur_req = "R4";
        step(0, 50, 0, 0, 0);
        step(1, 50, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0);     // spin end collides with read

        // R7: runs of slow samples
        cur_req = "R7";
        for (int i = 0; i < 4; i++) step(1, 150, 0, 0, 0);
        step(1, 50, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 150, 0, 0, 0);
        step(1, 150, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 150, 0, 0, 0);
        step(1, 150, 0, 0, 0);

        // R8: latch, clear, clear-vs-failure collision, over-speed independence
        cur_req = "R8";
        step(1, 50, 0, 1, 0);
        step(0, 0, 0, 0, 1);
        step(1, 5, 0, 0, 0);
        step(1, 60, 0, 0, 0);
        step(1, 5, 0, 1, 0);
        for (int i = 0; i < 4; i++) step(1, 120, 0, 0, 0);
        step(1, 120, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);

        // R9: interrupt gating
        cur_req = "R9";
        irq_en = 0;
        step(1, 130, 0, 0, 0);
        irq_en = 1;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0);

        // mixed sweep over every count residue with reads, clears and spin-up
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            irq_en = (i % 7) != 3;
            step((i % 5) != 4, (i * 37) % 130, (i % 50) < 6, (i % 3) == 0, (i % 41) == 0);
        end
        slow_limit = 16'd40; fast_limit = 16'd39;
        cur_req = "R1";
        for (int i = 0; i < 300; i++)
            step(1, (i * 11) % 64, (i % 60) > 55, (i % 4) == 0, (i % 97) == 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule